// File: doc/BRIEF.md
# Sensor function-command scratchpad controller

This block is the command layer of a single-wire temperature sensor slave. It takes over once the addressing layer above it has selected the device and pulsed `cmd_arm`. It then gathers an 8-bit command, least significant bit first, from write-bit strobes. It acts on that command against a nine-byte register image:

| Byte | Contents |
|------|----------|
| 0, 1 | Conversion result, low byte then high byte |
| 2 | Upper alarm threshold |
| 3 | Lower alarm threshold |
| 4 to 7 | Fixed pattern |
| 8 | CRC over bytes 0 to 7 |

Read slots are requested by `rd_req` and answered one cycle later on `rd_bit`, qualified by `rd_vld`. Long-running work is handed to two outside agents through single-cycle request pulses and done pulses: a conversion engine, and a nonvolatile store that saves or restores the two threshold bytes.

While such an operation runs, read slots can poll it: they return 0 while it is busy and 1 once it is finished. A threshold write only lands once both of its bytes have arrived. A bus reset drops the transaction in progress but lets an outside operation finish. At power-up the block restores the thresholds from the nonvolatile store on its own.

Top module: `scratch_cmd_ctrl`

## Requirements
- R1: After `cmd_arm`, eight write strobes form the command, with the first bit as bit 0. The codes are 8'h44 convert, 8'h4E write thresholds, 8'hBE read image, 8'h48 save, 8'hB8 restore and 8'hB4 power query. Any other code leaves the image untouched, and read slots return 1 until the next arm or bus reset.
- R2: Convert pulses `conv_req`. When `conv_done` arrives, `conv_temp[7:0]` lands in byte 0 and `conv_temp[15:8]` in byte 1. Read slots return 0 before that and 1 after.
- R3: Write thresholds takes 16 bits, least significant bit first. The first byte goes to byte 2 and the second to byte 3, and both are applied together in the cycle of the 16th strobe.
- R4: A bus reset before the 16th write bit discards the partial write, so bytes 2 and 3 keep their old values.
- R5: Read image returns 72 bits, from byte 0 bit 0 up to byte 8 bit 7. Any later slot returns 1.
- R6: Byte 8 always equals the CRC of bytes 0 to 7, fed byte 0 first and each byte least significant bit first. The register starts at 0, and each bit XORs 8'h8C into the right-shifted register when (register bit 0 XOR data bit) is 1.
- R7: Save pulses `nv_store_req` with `nv_wdata` = {byte 3, byte 2}. Read slots return 0 until `nv_done`, then 1.
- R8: Restore pulses `nv_load_req`. At `nv_done`, `nv_rdata[7:0]` goes to byte 2 and `nv_rdata[15:8]` to byte 3. Read slots return 0 before that and 1 after.
- R9: Synchronous reset leaves the image at bytes 0/1 = `PU_TEMP` and bytes 4 to 7 = `PU_RSVD`, with `rd_vld` low. `nv_load_req` pulses in the first cycle after reset, and read slots poll that restore without any command.
- R10: Power query answers its first read slot with 0 when `parasite` is 1 and with 1 otherwise. Later slots return 1.
- R11: A bus reset returns the block to idle, where read slots return 1 and an unfinished read ends. An outside operation still completes. Convert, save or restore issued while an operation is busy sends no new request and only polls it.
- R12: Each read slot is answered in the cycle after `rd_req` with `rd_vld` high.
- R13: Request pulses last one cycle, at most one is high at a time, and each is high only while an operation is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset pulse; ends the transaction |
| cmd_arm | input | 1 | Device selected; the next eight bits are a command |
| wr_stb | input | 1 | Write-bit strobe |
| wr_bit | input | 1 | Value of the written bit |
| rd_req | input | 1 | Read-slot request |
| rd_vld | output | 1 | Read-slot answer valid |
| rd_bit | output | 1 | Read-slot answer value |
| parasite | input | 1 | Device is powered from the data line |
| conv_req | output | 1 | Start-conversion pulse |
| conv_done | input | 1 | Conversion finished pulse |
| conv_temp | input | 16 | Conversion result |
| nv_store_req | output | 1 | Save-thresholds pulse |
| nv_load_req | output | 1 | Restore-thresholds pulse |
| nv_wdata | output | 16 | Thresholds to save, {byte 3, byte 2} |
| nv_rdata | input | 16 | Restored thresholds, {byte 3, byte 2} |
| nv_done | input | 1 | Nonvolatile operation finished pulse |

## Verification
The bench keeps `PU_TEMP` at its default of 16'h00AA. It sets `PU_RSVD` to 32'h5A3C_0FF0 instead of the default pattern, so the CRC is exercised over fixed bytes that differ from the usual ones. With that value the bench's own CRC model must agree on a byte 8 that no default-built image would produce. A wrong bit order or a wrong byte order in the CRC feed therefore shows up even when the thresholds happen to be zero.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int SP_BYTES = 9;
    localparam int SP_BITS  = SP_BYTES * 8;
    localparam int BODY_BITS = (SP_BYTES - 1) * 8;
    localparam int CNT_W    = $clog2(SP_BITS + 1);
    localparam int TEMP_W   = 16;
    localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        byte_t lo_thr;
        byte_t hi_thr;
    } thr_t;

    typedef enum logic [7:0] {
        CMD_CONVERT = 8'h44,
        CMD_WRITE   = 8'h4E,
        CMD_READ    = 8'hBE,
        CMD_SAVE    = 8'h48,
        CMD_RESTORE = 8'hB8,
        CMD_POWER   = 8'hB4
    } fcmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_WRITE, ST_READ, ST_POLL, ST_POWER, ST_MUTE
    } fstate_e;

    typedef enum logic [1:0] {
        OP_NONE, OP_CONV, OP_STORE, OP_LOAD
    } op_e;

    function automatic byte_t crc_step(byte_t c, logic b);
        logic fb;
        fb = c[0] ^ b;
        return {1'b0, c[7:1]} ^ (fb ? CRC_POLY_REFL : 8'h00);
    endfunction

    function automatic byte_t crc_over(logic [BODY_BITS-1:0] d);
        byte_t c;
        c = 8'h00;
        for (int i = 0; i < BODY_BITS; i++) c = crc_step(c, d[i]);
        return c;
    endfunction

endpackage

// File: rtl/sfc_scratch.sv
module sfc_scratch
    import sfc_pkg::*;
#(
    parameter logic [15:0] PU_TEMP = 16'h00AA,
    parameter logic [31:0] PU_RSVD = 32'h100C_FFFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               temp_we,
    input  logic [TEMP_W-1:0]  temp_d,
    input  logic               thr_we,
    input  thr_t               thr_d,
    output thr_t               thr_q,
    output logic [SP_BITS-1:0] image
);

    logic [TEMP_W-1:0]    temp_q;
    thr_t                 thr_r;
    logic [BODY_BITS-1:0] body;

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= PU_TEMP;
            thr_r  <= '0;
        end else begin
            if (temp_we) temp_q <= temp_d;
            if (thr_we)  thr_r  <= thr_d;
        end
    end

    // R6: check byte always follows the body
    assign body  = {PU_RSVD, thr_r.lo_thr, thr_r.hi_thr, temp_q};
    assign image = {crc_over(body), body};
    assign thr_q = thr_r;

    assert_thr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !thr_we |=> $stable(thr_r));

    assert_temp_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !temp_we |=> $stable(temp_q));

endmodule

// File: rtl/sfc_optrack.sv
module sfc_optrack
    import sfc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  op_e  kind,
    input  logic conv_done,
    input  logic nv_done,
    output logic busy,
    output logic fin_conv,
    output logic fin_load,
    output logic conv_req,
    output logic store_req,
    output logic load_req
);

    op_e  kind_q;
    logic boot_pend;
    logic fin_store;

    assign fin_conv  = busy && (kind_q == OP_CONV)  && conv_done;
    assign fin_load  = busy && (kind_q == OP_LOAD)  && nv_done;
    assign fin_store = busy && (kind_q == OP_STORE) && nv_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b1;
            kind_q    <= OP_LOAD;
            boot_pend <= 1'b1;
            conv_req  <= 1'b0;
            store_req <= 1'b0;
            load_req  <= 1'b0;
        end else begin
            conv_req  <= 1'b0;
            store_req <= 1'b0;
            load_req  <= boot_pend;
            boot_pend <= 1'b0;
            if (start && !busy) begin
                busy   <= 1'b1;
                kind_q <= kind;
                conv_req  <= (kind == OP_CONV);
                store_req <= (kind == OP_STORE);
                load_req  <= (kind == OP_LOAD);
            end else if (fin_conv || fin_load || fin_store) begin
                busy <= 1'b0;
            end
        end
    end

    assert_one_req_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({conv_req, store_req, load_req}));

    assert_req_busy_R13: assert property (@(posedge clk) disable iff (rst)
        (conv_req || store_req || load_req) |-> busy);

    assert_conv_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> !conv_req);

endmodule

// File: rtl/scratch_cmd_ctrl.sv
module scratch_cmd_ctrl
    import sfc_pkg::*;
#(
    parameter logic [15:0] PU_TEMP = 16'h00AA,
    parameter logic [31:0] PU_RSVD = 32'h100C_FFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_reset,
    input  logic        cmd_arm,
    input  logic        wr_stb,
    input  logic        wr_bit,
    input  logic        rd_req,
    output logic        rd_vld,
    output logic        rd_bit,
    input  logic        parasite,
    output logic        conv_req,
    input  logic        conv_done,
    input  logic [15:0] conv_temp,
    output logic        nv_store_req,
    output logic        nv_load_req,
    output logic [15:0] nv_wdata,
    input  logic [15:0] nv_rdata,
    input  logic        nv_done
);

    localparam logic [CNT_W-1:0] LAST_CMD_BIT = CNT_W'(7);
    localparam logic [CNT_W-1:0] LAST_WR_BIT  = CNT_W'(15);
    localparam logic [CNT_W-1:0] END_OF_IMAGE = CNT_W'(SP_BITS);

    fstate_e            st;
    logic [CNT_W-1:0]   cnt;
    logic [15:0]        sh;
    logic [15:0]        sh_nx;
    logic               bits_ok;
    logic               start;
    op_e                start_kind;
    logic               thr_we;
    thr_t               thr_d;
    thr_t               thr_q;
    logic               busy;
    logic               fin_conv;
    logic               fin_load;
    logic               slot_val;
    logic [SP_BITS-1:0] image;

    sfc_scratch #(.PU_TEMP(PU_TEMP), .PU_RSVD(PU_RSVD)) u_scratch (
        .clk(clk), .rst(rst),
        .temp_we(fin_conv), .temp_d(conv_temp),
        .thr_we(thr_we), .thr_d(thr_d), .thr_q(thr_q),
        .image(image)
    );

    sfc_optrack u_ops (
        .clk(clk), .rst(rst),
        .start(start), .kind(start_kind),
        .conv_done(conv_done), .nv_done(nv_done),
        .busy(busy), .fin_conv(fin_conv), .fin_load(fin_load),
        .conv_req(conv_req), .store_req(nv_store_req), .load_req(nv_load_req)
    );

    assign nv_wdata = thr_q;
    assign sh_nx    = {wr_bit, sh[15:1]};
    assign bits_ok  = wr_stb && !bus_reset && !cmd_arm;

    // Engine launch and threshold update
    always_comb begin
        start      = 1'b0;
        start_kind = OP_NONE;
        thr_we     = fin_load;
        thr_d      = nv_rdata;
        if (st == ST_CMD && bits_ok && cnt == LAST_CMD_BIT) begin
            case (sh_nx[15:8])
                CMD_CONVERT: begin start = 1'b1; start_kind = OP_CONV;  end
                CMD_SAVE:    begin start = 1'b1; start_kind = OP_STORE; end
                CMD_RESTORE: begin start = 1'b1; start_kind = OP_LOAD;  end
                default: ;
            endcase
        end
        if (st == ST_WRITE && bits_ok && cnt == LAST_WR_BIT) begin
            thr_we = 1'b1;
            thr_d  = sh_nx;
        end
    end

    // Answer for a read slot in the current state
    always_comb begin
        case (st)
            ST_READ:  slot_val = (cnt < END_OF_IMAGE) ? image[cnt] : 1'b1;
            ST_POLL:  slot_val = !busy;
            ST_POWER: slot_val = !parasite;
            default:  slot_val = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_POLL;
            cnt    <= '0;
            sh     <= '0;
            rd_vld <= 1'b0;
            rd_bit <= 1'b1;
        end else begin
            rd_vld <= rd_req;
            if (rd_req) rd_bit <= slot_val;
            if (bus_reset) begin
                st  <= ST_IDLE;
                cnt <= '0;
            end else if (cmd_arm) begin
                st  <= ST_CMD;
                cnt <= '0;
            end else begin
                case (st)
                    ST_CMD: if (wr_stb) begin
                        sh  <= sh_nx;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_CMD_BIT) begin
                            cnt <= '0;
                            case (sh_nx[15:8])
                                CMD_CONVERT, CMD_SAVE, CMD_RESTORE: st <= ST_POLL;
                                CMD_WRITE: st <= ST_WRITE;
                                CMD_READ:  st <= ST_READ;
                                CMD_POWER: st <= ST_POWER;
                                default:   st <= ST_MUTE;
                            endcase
                        end
                    end
                    ST_WRITE: if (wr_stb) begin
                        sh  <= sh_nx;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_WR_BIT) begin
                            cnt <= '0;
                            st  <= ST_MUTE;
                        end
                    end
                    ST_READ:  if (rd_req && cnt != END_OF_IMAGE) cnt <= cnt + 1'b1;
                    ST_POWER: if (rd_req) st <= ST_MUTE;
                    default: ;
                endcase
            end
        end
    end

    assert_busreset_idle_R11: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (st == ST_IDLE));

    assert_poll_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && st == ST_POLL && busy && !fin_conv && !fin_load && !nv_done)
            |=> (rd_vld && !rd_bit));

    assert_read_tail_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && st == ST_READ && cnt == END_OF_IMAGE) |=> (rd_vld && rd_bit));

    assert_power_answer_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && st == ST_POWER) |=> (rd_vld && rd_bit == !$past(parasite)));

    assert_slot_valid_R12: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_vld);

endmodule

// File: tb/tb_scratch_cmd_ctrl.sv
module tb_scratch_cmd_ctrl;

    localparam logic [15:0] TB_PU_TEMP = 16'h00AA;
    localparam logic [31:0] TB_PU_RSVD = 32'h5A3C_0FF0;
    localparam int NVEC = 6;
    localparam logic [15:0] WR_VEC [NVEC] = '{
        16'h0000, 16'hFFFF, 16'h1E4B, 16'h80_01, 16'h7F_C3, 16'h55_AA
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset = 1'b0, cmd_arm = 1'b0, wr_stb = 1'b0, wr_bit = 1'b0;
    logic rd_req = 1'b0, rd_vld, rd_bit, parasite = 1'b0;
    logic conv_req, conv_done = 1'b0, nv_store_req, nv_load_req, nv_done = 1'b0;
    logic [15:0] conv_temp = '0, nv_wdata, nv_rdata = '0;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_img [0:8];

    always #4 clk = ~clk;

    scratch_cmd_ctrl #(.PU_TEMP(TB_PU_TEMP), .PU_RSVD(TB_PU_RSVD)) dut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .cmd_arm(cmd_arm),
        .wr_stb(wr_stb), .wr_bit(wr_bit), .rd_req(rd_req), .rd_vld(rd_vld),
        .rd_bit(rd_bit), .parasite(parasite), .conv_req(conv_req),
        .conv_done(conv_done), .conv_temp(conv_temp), .nv_store_req(nv_store_req),
        .nv_load_req(nv_load_req), .nv_wdata(nv_wdata), .nv_rdata(nv_rdata),
        .nv_done(nv_done)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_crc();
        logic [7:0] c = 8'h00;
        for (int by = 0; by < 8; by++) begin
            logic [7:0] d = exp_img[by];
            for (int k = 0; k < 8; k++) begin
                logic mix = c[0] ^ d[k];
                c = c >> 1;
                if (mix) c = c ^ 8'h8C;
            end
        end
        return c;
    endfunction

    task automatic pulse_arm();
        @(negedge clk) cmd_arm = 1'b1;
        @(negedge clk) cmd_arm = 1'b0;
    endtask

    task automatic pulse_busrst();
        @(negedge clk) bus_reset = 1'b1;
        @(negedge clk) bus_reset = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) begin wr_stb = 1'b1; wr_bit = b; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int k = 0; k < 8; k++) send_bit(v[k]);
    endtask

    task automatic slot(output logic b);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        check("R12 slot valid", {15'd0, rd_vld}, 16'd1);
        b = rd_bit;
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int k = 0; k < 8; k++) begin
            logic b;
            slot(b);
            v[k] = b;
        end
    endtask

    task automatic nv_finish(input logic [15:0] d);
        @(negedge clk) begin nv_done = 1'b1; nv_rdata = d; end
        @(negedge clk) nv_done = 1'b0;
    endtask

    task automatic conv_finish(input logic [15:0] t);
        @(negedge clk) begin conv_done = 1'b1; conv_temp = t; end
        @(negedge clk) conv_done = 1'b0;
    endtask

    task automatic read_all(input string req);
        logic [7:0] v;
        logic b;
        exp_img[8] = model_crc();
        pulse_arm();
        send_byte(8'hBE);
        for (int by = 0; by < 9; by++) begin
            read_byte(v);
            check(req, {8'd0, v}, {8'd0, exp_img[by]});
        end
        slot(b);
        check("R5 after last bit", {15'd0, b}, 16'd1);
        pulse_busrst();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic b;
        logic [7:0] v;
        exp_img[0] = TB_PU_TEMP[7:0];  exp_img[1] = TB_PU_TEMP[15:8];
        exp_img[2] = 8'h00;            exp_img[3] = 8'h00;
        exp_img[4] = TB_PU_RSVD[7:0];  exp_img[5] = TB_PU_RSVD[15:8];
        exp_img[6] = TB_PU_RSVD[23:16]; exp_img[7] = TB_PU_RSVD[31:24];
        exp_img[8] = 8'h00;

        // R9: reset state and boot restore
        repeat (3) @(negedge clk);
        check("R9 rd_vld in reset", {15'd0, rd_vld}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 boot nv_load_req", {15'd0, nv_load_req}, 16'd1);
        @(negedge clk);
        check("R13 load pulse one cycle", {15'd0, nv_load_req}, 16'd0);
        slot(b);
        check("R9 boot poll busy", {15'd0, b}, 16'd0);
        nv_finish(16'h1E4B);
        exp_img[2] = 8'h4B; exp_img[3] = 8'h1E;
        slot(b);
        check("R8 boot poll done", {15'd0, b}, 16'd1);
        read_all("R5 R6 R9 boot image");

        // R3 R6: threshold write vectors
        for (int i = 0; i < NVEC; i++) begin
            pulse_arm();
            send_byte(8'h4E);
            send_byte(WR_VEC[i][7:0]);
            send_byte(WR_VEC[i][15:8]);
            pulse_busrst();
            exp_img[2] = WR_VEC[i][7:0];
            exp_img[3] = WR_VEC[i][15:8];
            read_all("R3 R6 write vector");
        end

        // R4: partial write discarded
        pulse_arm();
        send_byte(8'h4E);
        send_byte(8'h99);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        pulse_busrst();
        read_all("R4 partial write");

        // R2: convert with polling; write bits during poll ignored
        pulse_arm();
        send_byte(8'h44);
        check("R2 conv_req", {15'd0, conv_req}, 16'd1);
        slot(b);
        check("R2 poll busy", {15'd0, b}, 16'd0);
        send_byte(8'h4E);
        conv_finish(16'h0032);
        exp_img[0] = 8'h32; exp_img[1] = 8'h00;
        slot(b);
        check("R2 poll done", {15'd0, b}, 16'd1);
        pulse_busrst();
        read_all("R2 R6 conversion result");

        // R11: bus reset mid-operation, read aborted, busy blocks new request
        pulse_arm();
        send_byte(8'h44);
        pulse_busrst();
        slot(b);
        check("R11 idle slot", {15'd0, b}, 16'd1);
        pulse_arm();
        send_byte(8'hBE);
        read_byte(v);
        check("R11 partial read byte0", {8'd0, v}, {8'd0, exp_img[0]});
        pulse_busrst();
        pulse_arm();
        send_byte(8'h48);
        check("R11 no save while busy", {15'd0, nv_store_req}, 16'd0);
        slot(b);
        check("R11 poll shared busy", {15'd0, b}, 16'd0);
        conv_finish(16'hFFCE);
        exp_img[0] = 8'hCE; exp_img[1] = 8'hFF;
        slot(b);
        check("R11 poll after finish", {15'd0, b}, 16'd1);
        check("R11 still no save", {15'd0, nv_store_req}, 16'd0);
        pulse_busrst();
        read_all("R11 result landed after bus reset");

        // R7: save
        pulse_arm();
        send_byte(8'h48);
        check("R7 nv_store_req", {15'd0, nv_store_req}, 16'd1);
        check("R7 nv_wdata", nv_wdata, {exp_img[3], exp_img[2]});
        slot(b);
        check("R7 poll busy", {15'd0, b}, 16'd0);
        nv_finish(16'h0000);
        slot(b);
        check("R7 poll done", {15'd0, b}, 16'd1);
        pulse_busrst();

        // R8: restore
        pulse_arm();
        send_byte(8'hB8);
        check("R8 nv_load_req", {15'd0, nv_load_req}, 16'd1);
        slot(b);
        check("R8 poll busy", {15'd0, b}, 16'd0);
        nv_finish(16'h057D);
        exp_img[2] = 8'h7D; exp_img[3] = 8'h05;
        slot(b);
        check("R8 poll done", {15'd0, b}, 16'd1);
        pulse_busrst();
        read_all("R8 R6 restored thresholds");

        // R10: power query
        parasite = 1'b1;
        pulse_arm();
        send_byte(8'hB4);
        slot(b);
        check("R10 parasite answer", {15'd0, b}, 16'd0);
        slot(b);
        check("R10 second slot", {15'd0, b}, 16'd1);
        pulse_busrst();
        parasite = 1'b0;
        pulse_arm();
        send_byte(8'hB4);
        slot(b);
        check("R10 external answer", {15'd0, b}, 16'd1);
        pulse_busrst();

        // R1: unknown code ignored
        pulse_arm();
        send_byte(8'h12);
        slot(b);
        check("R1 unknown code slot", {15'd0, b}, 16'd1);
        send_byte(8'h00);
        send_byte(8'h00);
        check("R1 no request", {13'd0, conv_req, nv_store_req, nv_load_req}, 16'd0);
        pulse_busrst();
        read_all("R1 image untouched");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule